// File: doc/BRIEF.md
# UART Receive Byte Queue with Trigger Level and Character Timeout

This block holds the bytes a UART receiver delivers until the host reads them. In queued mode it keeps up to sixteen bytes in arrival order. It tells the interrupt logic when the fill level reaches a selectable threshold. It also flags a character timeout when data sits unread for four character times. When the queue is full, a new byte is dropped and an overrun flag is raised; stored bytes are never overwritten. A received line break enters the queue as a zero byte and raises a break flag.

In unqueued mode the block acts as a single holding byte. A byte that arrives while the previous one is still unread replaces it and raises overrun. The host drives a read strobe to consume the head byte, a status-read strobe to clear the sticky break and overrun flags, and a flush strobe to empty the queue. Changing the mode input flushes the queue in the same way.

Top module: `uart_rxq`

## Requirements
- R1: The queue stores up to DEPTH (16) bytes and returns them in arrival order on `rd_data`. `count` shows the number of stored bytes, and `data_ready` is high exactly when `count` is non-zero. After reset `count`, `data_ready`, `rd_data`, `overrun`, `brk` and `to_pend` are all 0.
- R2: In queued mode, a byte that arrives when `count`=16 with no read in the same cycle is discarded. Stored bytes are kept, `count` stays 16 and `overrun` is set.
- R3: In queued mode `trig_hit` is high when `count` reaches the threshold set by `trig_sel`: 2'b00=1, 2'b01=4, 2'b10=8, 2'b11=14 bytes. In single-byte mode it equals `data_ready`.
- R4: In queued mode `to_pend` rises on the fourth `char_tick` during which data is stored and no byte has arrived and no read has been made since the last such event. A new byte or a read restarts the count of ticks.
- R5: A read clears `to_pend`. A read of an empty queue shows `rd_data`=0x00 and leaves `count` at 0.
- R6: A read that empties the queue clears `data_ready` and `brk`. A status read (`stat_rd`) clears `brk` and `overrun`.
- R7: A break strobe stores a 0x00 byte and sets `brk` and `data_ready`.
- R8: A `flush` pulse, or any change of `fifo_en`, empties the queue and clears `to_pend` and `brk` on the next edge.
- R9: With `fifo_en`=0 the block holds one byte. A byte arriving while `data_ready` is high replaces the held byte and sets `overrun`.
- R10: A read and a byte arrival in the same cycle with the queue full act as a read followed by an accepted write. `count` stays 16 and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line break received strobe |
| rd_en | input | 1 | Host read of the head byte |
| stat_rd | input | 1 | Host status read, clears sticky flags |
| fifo_en | input | 1 | 1 = queued mode, 0 = single holding byte |
| flush | input | 1 | One-shot receive queue reset |
| trig_sel | input | 2 | Trigger threshold select |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | 8 | Head byte, 0x00 when empty |
| count | output | 5 | Bytes stored |
| data_ready | output | 1 | At least one byte stored |
| overrun | output | 1 | Sticky overrun flag |
| brk | output | 1 | Sticky break flag |
| trig_hit | output | 1 | Trigger level reached |
| to_pend | output | 1 | Character timeout pending |

## Verification
Every flag and the count come from registers, so each result is due on the first rising edge after the stimulus cycle. `rd_data` is decoded from the stored head, so it is valid in that same cycle. The bench drives inputs on falling edges for one cycle and checks at the next falling edge. For timeouts it counts ticks one at a time, so the fourth tick is the first point at which the pending flag is expected. A queue of expected bytes is filled by the driver task, and the read task takes from it and compares each head byte before it consumes it.

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int DEPTH    = 16,
  parameter int DW       = 8,
  parameter int TO_CHARS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  input  logic          rd_en,
  input  logic          stat_rd,
  input  logic          fifo_en,
  input  logic          flush,
  input  logic [1:0]    trig_sel,
  input  logic          char_tick,
  output logic [DW-1:0] rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic          data_ready,
  output logic          overrun,
  output logic          brk,
  output logic          trig_hit,
  output logic          to_pend
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = $clog2(TO_CHARS+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [TW-1:0] tcnt;
  logic          en_q;
  logic [CW-1:0] thr;

  wire          clr    = flush | (fifo_en != en_q);
  wire          push   = rx_valid | rx_break;
  wire [DW-1:0] wdat   = rx_break ? '0 : rx_data;
  wire          empty  = (count == '0);
  wire          full   = (count == CW'(DEPTH));
  wire          pop    = rd_en & ~empty;
  wire          do_wr  = en_q ? (push & (~full | pop)) : push;
  wire          ovf    = en_q ? (push & full & ~pop) : (push & ~empty & ~pop);
  wire [AW-1:0] wslot  = en_q ? wr_ptr : rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb
    case (trig_sel)
      2'b00:   thr = CW'(1);
      2'b01:   thr = CW'(4);
      2'b10:   thr = CW'(8);
      default: thr = CW'(14);
    endcase

  assign rd_data    = empty ? '0 : mem[rd_ptr];
  assign data_ready = ~empty;
  assign trig_hit   = en_q ? (count >= thr) : ~empty;

  always_ff @(posedge clk)
    if (do_wr && !clr) mem[wslot] <= wdat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; wr_ptr <= '0; rd_ptr <= '0; count <= '0;
      overrun <= 1'b0; brk <= 1'b0; tcnt <= '0; to_pend <= 1'b0;
    end else begin
      en_q <= fifo_en;
      if (clr) begin
        wr_ptr <= '0; rd_ptr <= '0; count <= '0;
        tcnt <= '0; to_pend <= 1'b0; brk <= 1'b0;
        if (stat_rd) overrun <= 1'b0;
      end else begin
        if (en_q) begin
          if (do_wr) wr_ptr <= nxt(wr_ptr);
          if (pop)   rd_ptr <= nxt(rd_ptr);
          count <= count + CW'(do_wr) - CW'(pop);
        end else if (do_wr) count <= CW'(1);
        else if (pop)       count <= '0;

        if (ovf)          overrun <= 1'b1;
        else if (stat_rd) overrun <= 1'b0;

        if (rx_break) brk <= 1'b1;
        else if (stat_rd || (pop && count == CW'(1) && !do_wr)) brk <= 1'b0;

        if (!en_q) begin
          tcnt <= '0; to_pend <= 1'b0;
        end else if (pop) begin
          tcnt <= '0; to_pend <= 1'b0;
        end else if (do_wr || empty) begin
          tcnt <= '0;
        end else if (char_tick && !to_pend) begin
          if (tcnt == TW'(TO_CHARS-1)) begin
            tcnt <= '0; to_pend <= 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
      end
    end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_full_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && fifo_en && !flush && full && push && !rd_en) |=> (full && overrun));

  assert_read_clears_to_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty) |=> !to_pend);

  assert_empty_no_to_R4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !to_pend);

  assert_single_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !fifo_en) |=> count <= CW'(1));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !to_pend));
endmodule

// File: tb/test_uart_rxq.sv
module test_uart_rxq;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_break = 0, rd_en = 0, stat_rd = 0, fifo_en = 0, flush = 0, char_tick = 0;
  logic [7:0] rx_data = 0;
  logic [1:0] trig_sel = 0;
  logic [7:0] rd_data;
  logic [4:0] count;
  logic data_ready, overrun, brk, trig_hit, to_pend;
  int tests = 0, fails = 0;
  logic [7:0] q[$];

  always #4 clk = ~clk;

  uart_rxq i_uart_rxq (.clk, .rst_n, .rx_valid, .rx_data, .rx_break, .rd_en, .stat_rd,
    .fifo_en, .flush, .trig_sel, .char_tick, .rd_data, .count, .data_ready, .overrun,
    .brk, .trig_hit, .to_pend);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic chkv(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic push(input logic [7:0] b, input bit keep);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
    if (keep) q.push_back(b);
  endtask

  task automatic rd(input string tag);
    logic [7:0] e;
    @(negedge clk);
    e = (q.size() > 0) ? q.pop_front() : 8'h00;
    chkv(tag, rd_data, e);
    rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); char_tick = 1;
    @(negedge clk); char_tick = 0;
  endtask

  task automatic pulse_stat();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
    chkv("R1 reset count", count, 0);
    chkv("R1 reset flags", {data_ready, overrun, brk, to_pend}, 0);
    chkv("R1 reset rd_data", rd_data, 0);

    fifo_en = 1; trig_sel = 2'b01;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 3; i++) push(8'h10 + i, 1);
    chkv("R3 below 4", trig_hit, 0);
    push(8'h13, 1);
    chkv("R3 at 4", trig_hit, 1);
    chkv("R1 count 4", count, 4);
    for (int i = 0; i < 4; i++) rd("R1 order");
    chkv("R1 drained ready", data_ready, 0);
    rd("R5 empty read data");
    chkv("R5 empty read count", count, 0);

    trig_sel = 2'b11;
    for (int i = 0; i < 13; i++) push(8'h40 + i, 1);
    chkv("R3 below 14", trig_hit, 0);
    push(8'h4D, 1);
    chkv("R3 at 14", trig_hit, 1);
    @(negedge clk); trig_sel = 2'b10; @(negedge clk);
    chkv("R3 sel 8", trig_hit, 1);
    push(8'h4E, 1); push(8'h4F, 1);
    chkv("R2 full count", count, 16);
    chkv("R2 no overrun yet", overrun, 0);
    push(8'hEE, 0);
    chkv("R2 overrun set", overrun, 1);
    chkv("R2 count held", count, 16);
    pulse_stat();
    chkv("R6 stat clears overrun", overrun, 0);

    @(negedge clk); rd_en = 1; rx_valid = 1; rx_data = 8'h5A;
    chkv("R10 head before", rd_data, q[0]);
    void'(q.pop_front()); q.push_back(8'h5A);
    @(negedge clk); rd_en = 0; rx_valid = 0;
    chkv("R10 count", count, 16);
    chkv("R10 no overrun", overrun, 0);
    for (int i = 0; i < 16; i++) rd("R2 R10 contents");
    chkv("R1 empty after drain", count, 0);

    push(8'h77, 1);
    for (int i = 0; i < 3; i++) pulse_tick();
    chkv("R4 three ticks", to_pend, 0);
    pulse_tick();
    chkv("R4 fourth tick", to_pend, 1);
    push(8'h78, 1);
    chkv("R4 byte keeps pending", to_pend, 1);
    rd("R5 read data");
    chkv("R5 read clears timeout", to_pend, 0);
    for (int i = 0; i < 3; i++) pulse_tick();
    push(8'h79, 1);
    for (int i = 0; i < 3; i++) pulse_tick();
    chkv("R4 byte restarts count", to_pend, 0);
    pulse_tick();
    chkv("R4 restarted fourth", to_pend, 1);
    rd("R4 drain"); rd("R4 drain");

    @(negedge clk); rx_break = 1;
    @(negedge clk); rx_break = 0;
    q.push_back(8'h00);
    chkv("R7 break flag", brk, 1);
    chkv("R7 ready", data_ready, 1);
    chkv("R7 zero byte", rd_data, 0);
    push(8'h33, 1);
    rd("R7 zero read");
    chkv("R6 break held while data", brk, 1);
    rd("R6 last read");
    chkv("R6 break cleared on empty", brk, 0);
    chkv("R6 ready cleared", data_ready, 0);

    push(8'h01, 0); push(8'h02, 0);
    for (int i = 0; i < 4; i++) pulse_tick();
    chkv("R4 pend before flush", to_pend, 1);
    @(negedge clk); flush = 1; @(negedge clk); flush = 0;
    chkv("R8 flush count", count, 0);
    chkv("R8 flush timeout", to_pend, 0);
    push(8'h03, 0);
    @(negedge clk); fifo_en = 0; @(negedge clk);
    chkv("R8 toggle flush", count, 0);

    push(8'h11, 0);
    chkv("R9 single count", count, 1);
    chkv("R9 trig equals ready", trig_hit, 1);
    push(8'h22, 1);
    chkv("R9 overrun", overrun, 1);
    chkv("R9 count stays 1", count, 1);
    rd("R9 replaced byte");
    chkv("R9 ready cleared", data_ready, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule